// File: doc/BRIEF.md
# Video Line and Field Timing Generator

This block turns the system clock into the raster timing of a console video output. A clock counter measures out each scan line, and a line counter groups lines into frames. The number of lines in a frame, and the number of clocks in a line, both follow a video-standard select input: 263 lines for the 60 Hz standard and 314 lines for the 50 Hz standard.

From that count the block produces the following signals:
- a vertical-blank flag, starting at line 240 and ending when the frame wraps;
- a single-cycle vertical-blank interrupt pulse;
- a strobe at the start of every line, for timers that count lines;
- a strobe at the start of every frame, for timer channels that clear once per frame;
- a running frame counter.

At each frame wrap the block also updates the interlace field bit and two video status bits. The field bit only follows frame parity when both interlace-enable status bits are set.

The clocks-per-line counts are parameters, one for each standard, so a test build can shorten the lines.

Top module: `vid_timing_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the outputs are as follows: line_num is 0, frame_cnt is 0, vblank, vblank_irq, hblank_stb, frame_stb, field and stat_odd are 0, and line_ctl is 1.
- R2: A line lasts CLK_PER_LINE_NTSC clocks when pal_sel is 0 and CLK_PER_LINE_PAL clocks when pal_sel is 1. If pal_sel changes in the middle of a line and the clock count already reaches the new length, the line ends at the next edge.
- R3: line_num counts 0 to 262 with pal_sel 0 and 0 to 313 with pal_sel 1, then wraps to 0. If a switch to the 60 Hz standard leaves line_num at 263 or above, the line wraps to 0 at the end of the current line.
- R4: hblank_stb is high for exactly the first cycle of every new line. This includes lines inside vertical blank and the wrap to line 0.
- R5: vblank rises in the cycle in which line_num becomes 240. It stays high until the cycle in which line_num becomes 0.
- R6: vblank_irq is a one-cycle pulse in the cycle in which vblank rises.
- R7: line_ctl goes to 0 together with the rise of vblank and returns to 1 at the frame wrap.
- R8: At the frame wrap, frame_cnt increments by one (modulo 2^FRAME_W) and frame_stb is high for that one cycle only.
- R9: At the frame wrap, field takes bit 0 of the new frame_cnt when ilace_en equals 2'b11. It takes 0 for any other value of ilace_en. field holds its value between wraps.
- R10: stat_odd inverts at each frame wrap where the new field value is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pal_sel | input | 1 | Video standard: 0 = 263-line, 1 = 314-line |
| ilace_en | input | 2 | Interlace-enable status bits; both set turns field tracking on |
| line_num | output | LINE_W | Current line in the frame |
| frame_cnt | output | FRAME_W | Frames completed since reset |
| field | output | 1 | Interlace field bit (status bit 31) |
| stat_odd | output | 1 | Status bit 13, inverted by each odd field |
| line_ctl | output | 1 | Line-control status bit, cleared during vertical blank |
| vblank | output | 1 | Vertical-blank flag |
| vblank_irq | output | 1 | One-cycle vertical-blank interrupt |
| hblank_stb | output | 1 | One-cycle strobe at each line start |
| frame_stb | output | 1 | One-cycle strobe at each frame start |

## Verification
Directed frames with both standards, each with interlace on and then off, separate the two line totals and show whether the field follows frame parity or stays at 0. A switch from the 50 Hz to the 60 Hz standard made at line 280 checks that a line past the new total wraps at once and is not left to run on. Random stimulus changes the standard partway through lines and frames and changes the interlace bits at random times. It is compared, cycle by cycle, against a reference model of the requirements held in the bench. This exposes off-by-one errors in line length, in the vblank start and in the strobe timing.

// File: rtl/vtg_pkg.sv
// Package: shared definitions for the video timing generator.
// Assumes: used by every module of the vid_timing_gen block.
package vtg_pkg;
    typedef enum logic {
        VSTD_60HZ = 1'b0,
        VSTD_50HZ = 1'b1
    } vstd_e;

    // Larger of two unsigned values, used to size the counters.
    function automatic int unsigned vmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/vtg_line_clk.sv
// Module: counts system clocks within one scan line and flags the last clock.
// Assumes: both clocks-per-line values are at least 2 and fit in CNT_W bits.
module vtg_line_clk
    import vtg_pkg::*;
#(
    parameter int unsigned CPL_60 = 2146,
    parameter int unsigned CPL_50 = 2157,
    parameter int unsigned CNT_W  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pal_sel,
    output logic line_end
);
    localparam logic [CNT_W-1:0] LAST_60 = CNT_W'(CPL_60 - 1);
    localparam logic [CNT_W-1:0] LAST_50 = CNT_W'(CPL_50 - 1);

    logic [CNT_W-1:0] clk_cnt;
    logic [CNT_W-1:0] last_sel;

    // Pick the terminal count of the current standard.
    always_comb begin
        last_sel = (vstd_e'(pal_sel) == VSTD_50HZ) ? LAST_50 : LAST_60;
        line_end = (clk_cnt >= last_sel);
    end

    // Advance the in-line clock count, restarting at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n)        clk_cnt <= '0;
        else if (line_end) clk_cnt <= '0;
        else               clk_cnt <= clk_cnt + 1'b1;
    end

    // R2: the count never passes the longer line length.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        clk_cnt <= CNT_W'(vmax(CPL_60, CPL_50) - 1));
endmodule

// File: rtl/vtg_frame_seq.sv
// Module: counts lines into frames; drives vblank, its interrupt, line and
// frame strobes, the line-control bit and the frame counter.
// Assumes: VBL_LINE lies below both line totals; line_end is one cycle wide.
module vtg_frame_seq
    import vtg_pkg::*;
#(
    parameter int unsigned LINES_60 = 263,
    parameter int unsigned LINES_50 = 314,
    parameter int unsigned VBL_LINE = 240,
    parameter int unsigned LINE_W   = 9,
    parameter int unsigned FRAME_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pal_sel,
    input  logic               line_end,
    output logic               wrap,
    output logic [LINE_W-1:0]  line_num,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               vblank,
    output logic               vblank_irq,
    output logic               hblank_stb,
    output logic               frame_stb,
    output logic               line_ctl
);
    localparam logic [LINE_W-1:0] TOT_60 = LINE_W'(LINES_60);
    localparam logic [LINE_W-1:0] TOT_50 = LINE_W'(LINES_50);
    localparam logic [LINE_W-1:0] VBL    = LINE_W'(VBL_LINE);

    logic [LINE_W-1:0] next_line;
    logic [LINE_W-1:0] total;

    // Decide whether the line ending now closes the frame.
    always_comb begin
        total     = (vstd_e'(pal_sel) == VSTD_50HZ) ? TOT_50 : TOT_60;
        next_line = line_num + 1'b1;
        wrap      = line_end && (next_line >= total);
    end

    // Step the line count and raise the per-line and per-frame events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_num   <= '0;
            frame_cnt  <= '0;
            vblank     <= 1'b0;
            vblank_irq <= 1'b0;
            hblank_stb <= 1'b0;
            frame_stb  <= 1'b0;
            line_ctl   <= 1'b1;
        end else begin
            hblank_stb <= line_end;
            vblank_irq <= 1'b0;
            frame_stb  <= 1'b0;
            if (wrap) begin
                line_num  <= '0;
                frame_cnt <= frame_cnt + 1'b1;
                frame_stb <= 1'b1;
                vblank    <= 1'b0;
                line_ctl  <= 1'b1;
            end else if (line_end) begin
                line_num <= next_line;
                if (next_line == VBL) begin
                    vblank     <= 1'b1;
                    vblank_irq <= 1'b1;
                    line_ctl   <= 1'b0;
                end
            end
        end
    end

    // R6: the interrupt never lasts two cycles.
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq);
    // R5: vblank only starts on the vblank line.
    a_r5_vblank_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> (line_num == VBL));
    // R8: the frame strobe only appears on line 0.
    a_r8_frame_line0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (line_num == '0));
    // R4: a line strobe is never followed by another.
    a_r4_hblank_single: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_stb |=> !hblank_stb);
    // R3: the line number stays below the larger total.
    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_num < LINE_W'(vmax(LINES_60, LINES_50)));
endmodule

// File: rtl/vtg_field.sv
// Module: updates the interlace field bit and the odd-field status bit at
// each frame wrap.
// Assumes: wrap is high in the cycle before the frame counter advances, and
// new_par is the parity the counter is about to take.
module vtg_field (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap,
    input  logic       new_par,
    input  logic [1:0] ilace_en,
    output logic       field,
    output logic       stat_odd
);
    logic new_field;

    // Field follows parity only when both interlace bits are set.
    always_comb new_field = (ilace_en == 2'b11) && new_par;

    // Latch the field and fold it into the odd bit at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field    <= 1'b0;
            stat_odd <= 1'b0;
        end else if (wrap) begin
            field    <= new_field;
            stat_odd <= stat_odd ^ new_field;
        end
    end

    // R9: the field holds between wraps.
    a_r9_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(field));
    // R10: the odd bit only moves when the field just became 1.
    a_r10_odd_needs_field: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_odd != $past(stat_odd)) |-> field);
endmodule

// File: rtl/vid_timing_gen.sv
// Module: top of the video line and field timing generator.
// Assumes: synchronous active-low reset; pal_sel and ilace_en are
// synchronous to clk.
module vid_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned CLK_PER_LINE_NTSC = 2146,
    parameter int unsigned CLK_PER_LINE_PAL  = 2157,
    parameter int unsigned LINES_NTSC        = 263,
    parameter int unsigned LINES_PAL         = 314,
    parameter int unsigned VBL_LINE          = 240,
    parameter int unsigned FRAME_W           = 16,
    localparam int unsigned CNT_W  = $clog2(vmax(CLK_PER_LINE_NTSC, CLK_PER_LINE_PAL)),
    localparam int unsigned LINE_W = $clog2(vmax(LINES_NTSC, LINES_PAL) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pal_sel,
    input  logic [1:0]         ilace_en,
    output logic [LINE_W-1:0]  line_num,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               field,
    output logic               stat_odd,
    output logic               line_ctl,
    output logic               vblank,
    output logic               vblank_irq,
    output logic               hblank_stb,
    output logic               frame_stb
);
    logic line_end;
    logic wrap;

    vtg_line_clk #(
        .CPL_60(CLK_PER_LINE_NTSC),
        .CPL_50(CLK_PER_LINE_PAL),
        .CNT_W (CNT_W)
    ) u_line_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pal_sel (pal_sel),
        .line_end(line_end)
    );

    vtg_frame_seq #(
        .LINES_60(LINES_NTSC),
        .LINES_50(LINES_PAL),
        .VBL_LINE(VBL_LINE),
        .LINE_W  (LINE_W),
        .FRAME_W (FRAME_W)
    ) u_frame_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_sel   (pal_sel),
        .line_end  (line_end),
        .wrap      (wrap),
        .line_num  (line_num),
        .frame_cnt (frame_cnt),
        .vblank    (vblank),
        .vblank_irq(vblank_irq),
        .hblank_stb(hblank_stb),
        .frame_stb (frame_stb),
        .line_ctl  (line_ctl)
    );

    vtg_field u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .new_par (~frame_cnt[0]),
        .ilace_en(ilace_en),
        .field   (field),
        .stat_odd(stat_odd)
    );

    // R7: the line-control bit is low exactly while in vertical blank.
    a_r7_lctl_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl == !vblank);
endmodule

// File: tb/vid_timing_gen_tb.sv
// Bench: directed frames plus seeded random standard and interlace changes,
// compared each cycle against a reference model of the requirements.
module vid_timing_gen_tb;
    localparam int CPL_N = 5;
    localparam int CPL_P = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_sel = 1'b0;
    logic [1:0]  ilace_en = 2'b00;
    logic [8:0]  line_num;
    logic [15:0] frame_cnt;
    logic        field, stat_odd, line_ctl, vblank, vblank_irq, hblank_stb, frame_stb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_pix, m_line, m_frame, m_vb, m_irq, m_hb, m_fs, m_lcf, m_field, m_odd;

    always #5 clk = ~clk;

    vid_timing_gen #(
        .CLK_PER_LINE_NTSC(CPL_N),
        .CLK_PER_LINE_PAL (CPL_P)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .ilace_en(ilace_en),
        .line_num(line_num), .frame_cnt(frame_cnt), .field(field),
        .stat_odd(stat_odd), .line_ctl(line_ctl), .vblank(vblank),
        .vblank_irq(vblank_irq), .hblank_stb(hblank_stb), .frame_stb(frame_stb)
    );

    function automatic int cpl_of(input logic p);
        return p ? CPL_P : CPL_N;
    endfunction

    function automatic int lines_of(input logic p);
        return p ? 314 : 263;
    endfunction

    // reference model advanced at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pix = 0; m_line = 0; m_frame = 0; m_vb = 0; m_irq = 0;
            m_hb = 0; m_fs = 0; m_lcf = 1; m_field = 0; m_odd = 0;
        end else begin
            m_hb = 0; m_irq = 0; m_fs = 0;
            if (m_pix >= cpl_of(pal_sel) - 1) begin
                m_pix = 0;
                m_hb = 1;
                if (m_line + 1 >= lines_of(pal_sel)) begin
                    m_line = 0;
                    m_frame = (m_frame + 1) % 65536;
                    m_fs = 1; m_vb = 0; m_lcf = 1;
                    m_field = (ilace_en == 2'b11) ? (m_frame % 2) : 0;
                    if (m_field == 1) m_odd = 1 - m_odd;
                end else begin
                    m_line = m_line + 1;
                    if (m_line == 240) begin
                        m_vb = 1; m_irq = 1; m_lcf = 0;
                    end
                end
            end else begin
                m_pix = m_pix + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 line_num", int'(line_num), m_line);
        chk("R8 frame_cnt", int'(frame_cnt), m_frame);
        chk("R5 vblank", int'(vblank), m_vb);
        chk("R6 vblank_irq", int'(vblank_irq), m_irq);
        chk("R4/R2 hblank_stb", int'(hblank_stb), m_hb);
        chk("R8 frame_stb", int'(frame_stb), m_fs);
        chk("R7 line_ctl", int'(line_ctl), m_lcf);
        chk("R9 field", int'(field), m_field);
        chk("R10 stat_odd", int'(stat_odd), m_odd);
    endtask

    // run n cycles, comparing away from the active edge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 line_num", int'(line_num), 0);
        chk("R1 frame_cnt", int'(frame_cnt), 0);
        chk("R1 vblank", int'(vblank), 0);
        chk("R1 strobes", int'({vblank_irq, hblank_stb, frame_stb}), 0);
        chk("R1 field", int'({field, stat_odd}), 0);
        chk("R1 line_ctl", int'(line_ctl), 1);
        rst_n = 1'b1;

        // 60 Hz with interlace on for three frames: field follows parity
        ilace_en = 2'b11; pal_sel = 1'b0;
        run(3 * 263 * CPL_N + 4);
        chk("R9 field after odd frame count", int'(field), int'(frame_cnt[0]));

        // 50 Hz with interlace off: field forced to 0
        ilace_en = 2'b01; pal_sel = 1'b1;
        run(2 * 314 * CPL_P);
        chk("R9 field with interlace off", int'(field), 0);

        // corner: switch to 60 Hz while past line 263
        while (line_num != 9'd280) run(1);
        pal_sel = 1'b0;
        run(CPL_P + 2);
        chk("R3 wrap after standard switch", int'(line_num), 0);

        // random standard and interlace changes
        for (int i = 0; i < 60000; i++) begin
            if ($urandom_range(0, 2999) == 0) pal_sel = ~pal_sel;
            if ($urandom_range(0, 1999) == 0) ilace_en = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 4999) == 0) ilace_en = 2'b11;
            run(1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule